// File: doc/BRIEF.md
# Free-Running Stream to Valid/Ready Adapter

This block takes a producer that cannot be stalled and turns its output into a valid/ready stream. The producer presents a data word and a present flag each cycle. A word it offers must be taken in that cycle or it is lost. The adapter captures accepted words in a single holding register. Output data and valid therefore come from a flop and stay steady while the consumer holds ready low.

Some words cannot be delivered. If a word arrives while the register is occupied and the consumer is stalling, the held word stays in place and the arriving word is discarded. Each discard increments an unsigned counter of `CNT_W` bits, which wraps. If the held word completes its handshake in the same cycle a new word arrives, the new word takes its place and nothing is lost.

Top module: `stream_latch_adapter`

## Requirements
- R1: While `rst_ni` is low, `out_vld_o` is 0. After reset, `drop_cnt_o` is 0 and no word is held.
- R2: A word offered (`in_vld_i`=1) while nothing is held is loaded. On the next cycle, `out_vld_o`=1 and `out_data_o` equals that word.
- R3: While `out_vld_o`=1 and `out_rdy_i`=0, the next cycle keeps `out_vld_o`=1 with `out_data_o` unchanged.
- R4: A word offered while a word is held and `out_rdy_i`=0 is dropped. The held word is kept and `drop_cnt_o` increases by one on the next cycle.
- R5: A word offered in the cycle the held word completes its handshake replaces it on the next cycle, and `drop_cnt_o` does not change.
- R6: A handshake (`out_vld_o`=1, `out_rdy_i`=1) with no word offered leaves `out_vld_o`=0 on the next cycle.
- R7: `drop_cnt_o` counts modulo 2^`CNT_W`, so a drop at the all-ones value gives 0.
- R8: While `in_vld_i`=0, `in_data_i` has no effect on `out_vld_o`, `out_data_o` or `drop_cnt_o`. `drop_cnt_o` changes only on a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | DATA_W | Producer data word |
| in_vld_i | input | 1 | Producer word present |
| out_data_o | output | DATA_W | Held word to consumer |
| out_vld_o | output | 1 | Held word valid |
| out_rdy_i | input | 1 | Consumer ready |
| drop_cnt_o | output | CNT_W | Count of discarded words, wrapping |

## Verification
The bench builds the adapter with `DATA_W`=8 and `CNT_W`=3. With a 3-bit counter, eight drops carry the count past its all-ones value, so the wrap to zero is checked in a short run; the default 16-bit counter would need tens of thousands of drops. The 8-bit data width is wide enough to give each word in a sequence its own value. A held word can then be told apart from a word that replaced it or was dropped.

// File: rtl/sla_pkg.sv
package sla_pkg;
  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_LOAD  = 2'd1,
    EV_DROP  = 2'd2,
    EV_DRAIN = 2'd3
  } sla_ev_e;

  // One event per cycle: load wins over drain, since a freed slot is refilled at once.
  function automatic sla_ev_e sla_classify(input logic vld, input logic held, input logic rdy);
    if (vld && (!held || rdy)) return EV_LOAD;
    if (vld)                   return EV_DROP;
    if (held && rdy)           return EV_DRAIN;
    return EV_IDLE;
  endfunction
endpackage

// File: rtl/sla_hold_stage.sv
module sla_hold_stage
  import sla_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sla_ev_e           ev_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              held_o
);
  logic [DATA_W-1:0] data_q;
  logic              held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
    end else begin
      case (ev_i)
        EV_LOAD:  held_q <= 1'b1;
        EV_DRAIN: held_q <= 1'b0;
        default:  held_q <= held_q;
      endcase
    end
  end

  // Data needs no reset; it is qualified by held_q.
  always_ff @(posedge clk_i) begin
    if (ev_i == EV_LOAD) data_q <= data_i;
  end

  assign data_o = data_q;
  assign held_o = held_q;
endmodule

// File: rtl/sla_drop_ctr.sv
module sla_drop_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CntOne;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stream_latch_adapter.sv
module stream_latch_adapter
  import sla_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_vld_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_vld_o,
  input  logic              out_rdy_i,
  output logic [CNT_W-1:0]  drop_cnt_o
);
  sla_ev_e ev;
  logic    held;

  assign ev = sla_classify(in_vld_i, held, out_rdy_i);

  sla_hold_stage #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .data_i (in_data_i),
    .data_o (out_data_o),
    .held_o (held)
  );

  sla_drop_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ev == EV_DROP),
    .cnt_o  (drop_cnt_o)
  );

  assign out_vld_o = held;
endmodule

// File: rtl/stream_latch_adapter_chk.sv
module stream_latch_adapter_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] in_data_i,
  input logic              in_vld_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_vld_o,
  input logic              out_rdy_i,
  input logic [CNT_W-1:0]  drop_cnt_o
);
  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RST_NO_VLD: assert (!out_vld_o); // R1
  end

  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_vld_i && (!out_vld_o || out_rdy_i) |=> out_vld_o && out_data_o == $past(in_data_i)); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o && !out_rdy_i |=> out_vld_o && $stable(out_data_o)); // R3

  AST_DROP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_vld_i && out_vld_o && !out_rdy_i |=> drop_cnt_o == $past(drop_cnt_o) + CntOne); // R4

  AST_NO_DROP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_vld_i && out_vld_o && !out_rdy_i) |=> $stable(drop_cnt_o)); // R8

  AST_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_vld_i && out_vld_o && out_rdy_i |=> !out_vld_o); // R6
endmodule

bind stream_latch_adapter stream_latch_adapter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/stream_latch_adapter_tb.sv
module stream_latch_adapter_tb;
  localparam int DW = 8;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_vld = 1'b0;
  logic          out_rdy = 1'b0;
  logic [DW-1:0] out_data;
  logic          out_vld;
  logic [CW-1:0] drop_cnt;

  int n_chk = 0;
  int n_err = 0;
  logic [CW-1:0] exp_cnt = '0;

  always #10 clk = ~clk;

  stream_latch_adapter #(.DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_data_i(in_data), .in_vld_i(in_vld),
    .out_data_o(out_data), .out_vld_o(out_vld), .out_rdy_i(out_rdy), .drop_cnt_o(drop_cnt)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at negedge, let one rising edge pass, sample 1 ns later.
  task automatic step(logic v, logic [DW-1:0] d, logic r);
    @(negedge clk);
    in_vld = v; in_data = d; out_rdy = r;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 vld in reset", 32'(out_vld), 0);
    @(negedge clk); rst_ni = 1'b1;
    #1;
    chk("R1 cnt after reset", 32'(drop_cnt), 0);
    chk("R1 vld after reset", 32'(out_vld), 0);
  endtask

  task automatic t_pass();
    step(1, 8'hA5, 1);
    chk("R2 vld", 32'(out_vld), 1);
    chk("R2 data", 32'(out_data), 32'hA5);
    step(0, 8'h00, 1);
    chk("R6 drained", 32'(out_vld), 0);
  endtask

  task automatic t_stall();
    step(1, 8'h11, 0);
    chk("R2 load", 32'(out_data), 32'h11);
    step(0, 8'h00, 0);
    chk("R3 vld held", 32'(out_vld), 1);
    chk("R3 data held", 32'(out_data), 32'h11);
    step(1, 8'h22, 0);
    exp_cnt++;
    chk("R4 held kept", 32'(out_data), 32'h11);
    chk("R4 cnt", 32'(drop_cnt), 32'(exp_cnt));
    step(1, 8'h33, 1);
    chk("R5 replaced", 32'(out_data), 32'h33);
    chk("R5 vld", 32'(out_vld), 1);
    chk("R5 no drop", 32'(drop_cnt), 32'(exp_cnt));
    step(0, 8'h00, 1);
    chk("R6 drained", 32'(out_vld), 0);
  endtask

  task automatic t_ignore();
    step(0, 8'hEE, 1);
    chk("R8 idle vld", 32'(out_vld), 0);
    step(0, 8'h77, 0);
    chk("R8 idle vld stall", 32'(out_vld), 0);
    chk("R8 idle cnt", 32'(drop_cnt), 32'(exp_cnt));
    step(1, 8'h44, 0);
    step(0, 8'h99, 0);
    chk("R8 held data", 32'(out_data), 32'h44);
    chk("R8 held cnt", 32'(drop_cnt), 32'(exp_cnt));
    step(0, 8'h00, 1);
    chk("R6 drained", 32'(out_vld), 0);
  endtask

  task automatic t_wrap();
    step(1, 8'h55, 0);
    for (int i = 0; i < 8; i++) begin
      step(1, 8'(8'h60 + i), 0);
      exp_cnt++;
      chk("R4 cnt step", 32'(drop_cnt), 32'(exp_cnt));
    end
    chk("R7 wrapped value", 32'(drop_cnt), 32'(CW'(1)));
    chk("R4 held survives", 32'(out_data), 32'h55);
    step(0, 8'h00, 1);
    chk("R6 drained", 32'(out_vld), 0);
  endtask

  task automatic t_reset_mid();
    step(1, 8'h3C, 0);
    chk("R2 load", 32'(out_vld), 1);
    @(negedge clk); rst_ni = 1'b0;
    #1;
    chk("R1 vld forced low", 32'(out_vld), 0);
    chk("R1 cnt cleared", 32'(drop_cnt), 0);
    @(negedge clk); in_vld = 1'b0; rst_ni = 1'b1;
    exp_cnt = '0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_pass();
        t_stall();
        t_ignore();
        t_wrap();
        t_reset_mid();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule